// File: doc/BRIEF.md
# Falling-Edge Event Counter

This block counts falling edges seen on an asynchronous external input. The input is brought into the system clock domain through a chain of flip-flops. The last two stages are then compared to find a high-to-low transition. Each such transition adds one to a wide counter. The counter wraps silently when it passes its largest value.

A host reaches the count through two strobes, a read and a clear. The two may arrive in the same cycle. In that case the read returns the value from just before the clear, so the host can take a reading and restart from zero in one operation.

An availability input gates the whole function. While it is low, the block counts nothing and releases its claim on the pin. The count already held is kept for later reads.

Top module: `fall_event_counter`

## Requirements
- R1: After reset the count is 0, `rd_valid_o` is 0 and `pin_claim_o` is 0.
- R2: Each high-to-low transition of `pin_i` adds exactly one to the count, provided each level is held for at least two clock cycles. Rising transitions add nothing.
- R3: A cycle with `rd_i` high is followed by a single cycle with `rd_valid_o` high. In that cycle `rd_data_o` holds the count as it stood in the cycle of the read. `rd_valid_o` is low in every cycle not preceded by a read.
- R4: When `rd_i` and `clr_i` are high in the same cycle, the returned data is the count before the clear, and the count afterwards is 0.
- R5: A cycle with `clr_i` high and no detected edge sets the count to 0.
- R6: A detected edge in the same cycle as `clr_i` is counted after the clear, so the count becomes 1.
- R7: While `avail_i` is low, falling transitions on `pin_i` do not change the count, and the held count is preserved. `pin_claim_o` follows `avail_i` one cycle late.
- R8: A detected edge is counted only if `avail_i` is high both in the detection cycle and in the cycle before it.
- R9: The counter is `CNT_W` bits wide, 32 by default. An edge at the all-ones value wraps the count to 0, with no saturation.
- R10: A read in the same cycle as a detected edge returns the count before that edge is added.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pin_i | input | 1 | Asynchronous external event input |
| avail_i | input | 1 | Counter available; low disables counting and releases the pin |
| rd_i | input | 1 | Read strobe, one cycle |
| clr_i | input | 1 | Clear strobe, one cycle |
| rd_data_o | output | CNT_W | Registered read data |
| rd_valid_o | output | 1 | Read data valid, one cycle after `rd_i` |
| pin_claim_o | output | 1 | Pin in use by the counter |

## Verification
The assertions assume that the pin holds each level for at least two clock cycles. Without that, the synchroniser could merge two transitions and no single edge would be visible. The assertions also assume that the read and clear strobes are plain synchronous levels, sampled once per cycle. The stimulus drives every pulse with three cycles per level and changes all inputs on the falling clock edge. The only exceptions are the coincidence cases. There the strobes are placed, by cycle count, into the one cycle in which the edge is detected, which is the third rising edge after the pin drops.

// File: rtl/evcnt_pkg.sv
package evcnt_pkg;
  localparam int unsigned EVCNT_W_DEF    = 32;
  localparam int unsigned EVCNT_SYNC_DEF = 2;
  // idle level of the pin: a falling edge leaves this level
  localparam logic        PIN_IDLE       = 1'b1;
endpackage

// File: rtl/evcnt_sync.sv
module evcnt_sync
  import evcnt_pkg::*;
#(
  parameter int unsigned STAGES = EVCNT_SYNC_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q[0] <= PIN_IDLE;
    else         chain_q[0] <= d_i;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q[i] <= PIN_IDLE;
      else         chain_q[i] <= chain_q[i-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/evcnt_edge.sv
module evcnt_edge
  import evcnt_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_i,
  input  logic avail_i,
  output logic fall_o,
  output logic claim_o
);
  logic prev_q;
  logic avail_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= PIN_IDLE;
      avail_q <= 1'b0;
    end else begin
      prev_q  <= sync_i;
      avail_q <= avail_i;
    end
  end

  // edge qualified by availability in this and the previous cycle
  assign fall_o  = prev_q & ~sync_i & avail_i & avail_q;
  assign claim_o = avail_q;

  // R2: two edges need a low level in between
  fall_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o);

  // R8
  fall_avail_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |-> $past(avail_i));
endmodule

// File: rtl/evcnt_core.sv
module evcnt_core
  import evcnt_pkg::*;
#(
  parameter int unsigned CNT_W = EVCNT_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CntOne  = CNT_W'(1);
  localparam logic [CNT_W-1:0] CntZero = '0;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= CntZero;
    else if (clr_i)  cnt_q <= inc_i ? CntOne : CntZero;
    else if (inc_i)  cnt_q <= cnt_q + CntOne;
  end

  assign cnt_o = cnt_q;

  // R2
  step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + CntOne));

  // R5
  clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == CntZero || cnt_q == CntOne));

  // R7
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc_i && !clr_i) |=> $stable(cnt_q));
endmodule

// File: rtl/evcnt_rdport.sv
module evcnt_rdport #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rd_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [CNT_W-1:0] rd_data_o,
  output logic             rd_valid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_data_o  <= '0;
      rd_valid_o <= 1'b0;
    end else begin
      rd_valid_o <= rd_i;
      if (rd_i) rd_data_o <= cnt_i;
    end
  end

  // R3
  rd_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |=> (rd_valid_o && rd_data_o == $past(cnt_i)));

  // R3
  rd_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> !rd_valid_o);
endmodule

// File: rtl/fall_event_counter.sv
module fall_event_counter
  import evcnt_pkg::*;
#(
  parameter int unsigned CNT_W       = EVCNT_W_DEF,
  parameter int unsigned SYNC_STAGES = EVCNT_SYNC_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pin_i,
  input  logic             avail_i,
  input  logic             rd_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] rd_data_o,
  output logic             rd_valid_o,
  output logic             pin_claim_o
);
  logic             pin_sync;
  logic             fall;
  logic [CNT_W-1:0] cnt;

  evcnt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (pin_sync)
  );

  evcnt_edge u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sync_i (pin_sync),
    .avail_i(avail_i),
    .fall_o (fall),
    .claim_o(pin_claim_o)
  );

  evcnt_core #(.CNT_W(CNT_W)) u_core (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .inc_i (fall),
    .clr_i (clr_i),
    .cnt_o (cnt)
  );

  evcnt_rdport #(.CNT_W(CNT_W)) u_rd (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_i      (rd_i),
    .cnt_i     (cnt),
    .rd_data_o (rd_data_o),
    .rd_valid_o(rd_valid_o)
  );

  // R7
  claim_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (pin_claim_o == $past(avail_i)));
endmodule

// File: tb/tb_fall_event_counter.sv
module tb_fall_event_counter;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        pin_i = 1'b1;
  logic        avail_i = 1'b1;
  logic        rd_i = 1'b0;
  logic        clr_i = 1'b0;
  logic [31:0] rd_data_o;
  logic        rd_valid_o;
  logic        pin_claim_o;
  logic [3:0]  w_data;
  logic        w_valid;
  logic        w_claim;

  int unsigned checks = 0;
  int unsigned errors = 0;
  int unsigned exp_cnt = 0;
  bit          done = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #4 clk_i = ~clk_i;

  fall_event_counter dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .pin_i(pin_i), .avail_i(avail_i),
    .rd_i(rd_i), .clr_i(clr_i), .rd_data_o(rd_data_o),
    .rd_valid_o(rd_valid_o), .pin_claim_o(pin_claim_o)
  );

  fall_event_counter #(.CNT_W(4)) wrap_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .pin_i(pin_i), .avail_i(avail_i),
    .rd_i(rd_i), .clr_i(clr_i), .rd_data_o(w_data),
    .rd_valid_o(w_valid), .pin_claim_o(w_claim)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // monitor: pop expected read results
  initial begin
    forever begin
      @(negedge clk_i);
      if (rd_valid_o) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R3 unexpected valid", 32'd1, 32'd0);
        end else begin
          automatic logic [31:0] e = exp_q.pop_front();
          automatic string t = tag_q.pop_front();
          check(rd_data_o === e, t, rd_data_o, e);
        end
      end
    end
  end

  task automatic do_read(input logic [31:0] e, input string t, input bit with_clr);
    @(negedge clk_i);
    exp_q.push_back(e);
    tag_q.push_back(t);
    rd_i = 1'b1;
    clr_i = with_clr;
    @(negedge clk_i);
    rd_i = 1'b0;
    clr_i = 1'b0;
    @(negedge clk_i);
  endtask

  task automatic pulse(input bit counts);
    @(negedge clk_i);
    pin_i = 1'b0;
    repeat (3) @(negedge clk_i);
    pin_i = 1'b1;
    repeat (3) @(negedge clk_i);
    if (counts) exp_cnt++;
  endtask

  // drive a strobe exactly in the detection cycle of a new edge
  task automatic edge_with(input bit use_rd, input bit use_clr);
    @(negedge clk_i);
    pin_i = 1'b0;
    @(negedge clk_i);
    @(negedge clk_i);
    rd_i = use_rd;
    clr_i = use_clr;
    @(negedge clk_i);
    rd_i = 1'b0;
    clr_i = 1'b0;
    repeat (2) @(negedge clk_i);
    pin_i = 1'b1;
    repeat (3) @(negedge clk_i);
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk_i);
    // R1 reset state
    check(rd_valid_o === 1'b0, "R1 valid", {31'd0, rd_valid_o}, 32'd0);
    check(pin_claim_o === 1'b0, "R1 claim", {31'd0, pin_claim_o}, 32'd0);
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    do_read(32'd0, "R1 count", 1'b0);
    check(pin_claim_o === 1'b1, "R7 claim high", {31'd0, pin_claim_o}, 32'd1);

    // R2 several edges
    pulse(1'b1);
    do_read(exp_cnt, "R2 one edge", 1'b0);
    for (int i = 0; i < 4; i++) pulse(1'b1);
    do_read(exp_cnt, "R2 five edges", 1'b0);
    // R2 rising only: drop then wait, then rise and read before next drop
    @(negedge clk_i); pin_i = 1'b0; repeat (4) @(negedge clk_i);
    exp_cnt++;
    do_read(exp_cnt, "R2 after fall", 1'b0);
    pin_i = 1'b1; repeat (4) @(negedge clk_i);
    do_read(exp_cnt, "R2 rise ignored", 1'b0);

    // R3 back-to-back reads
    do_read(exp_cnt, "R3 read a", 1'b0);
    do_read(exp_cnt, "R3 read b", 1'b0);

    // R4 read with clear
    do_read(exp_cnt, "R4 pre-clear value", 1'b1);
    exp_cnt = 0;
    do_read(32'd0, "R4 cleared", 1'b0);

    // R5 plain clear
    pulse(1'b1); pulse(1'b1);
    do_read(exp_cnt, "R5 before", 1'b0);
    @(negedge clk_i); clr_i = 1'b1; @(negedge clk_i); clr_i = 1'b0;
    exp_cnt = 0;
    do_read(32'd0, "R5 after clear", 1'b0);

    // R6 edge with clear
    pulse(1'b1); pulse(1'b1); pulse(1'b1);
    edge_with(1'b0, 1'b1);
    exp_cnt = 1;
    do_read(exp_cnt, "R6 edge on clear", 1'b0);

    // R10 read coinciding with edge
    pulse(1'b1);
    exp_q.push_back(exp_cnt);
    tag_q.push_back("R10 pre-edge value");
    edge_with(1'b1, 1'b0);
    exp_cnt++;
    do_read(exp_cnt, "R10 edge counted", 1'b0);

    // R7 unavailable: edges ignored, count held
    @(negedge clk_i); avail_i = 1'b0; @(negedge clk_i);
    check(pin_claim_o === 1'b0, "R7 claim released", {31'd0, pin_claim_o}, 32'd0);
    pulse(1'b0); pulse(1'b0);
    do_read(exp_cnt, "R7 held while off", 1'b0);
    avail_i = 1'b1;
    repeat (3) @(negedge clk_i);
    pulse(1'b1);
    do_read(exp_cnt, "R7 counts again", 1'b0);

    // R8 availability dropped only in the cycle before detection
    @(negedge clk_i); pin_i = 1'b0;
    @(negedge clk_i); avail_i = 1'b0;
    @(negedge clk_i); avail_i = 1'b1;
    repeat (3) @(negedge clk_i); pin_i = 1'b1; repeat (3) @(negedge clk_i);
    do_read(exp_cnt, "R8 gated edge", 1'b0);

    // R9 wrap on the 4-bit instance
    do_read(exp_cnt, "R9 clear main", 1'b1);
    exp_cnt = 0;
    for (int i = 0; i < 15; i++) pulse(1'b1);
    do_read(exp_cnt, "R9 main 15", 1'b0);
    check(w_data === 4'hF, "R9 all ones", {28'd0, w_data}, 32'hF);
    pulse(1'b1);
    do_read(exp_cnt, "R9 main 16", 1'b0);
    check(w_data === 4'h0, "R9 wrapped", {28'd0, w_data}, 32'h0);

    repeat (4) @(negedge clk_i);
    check(exp_q.size() == 0, "R3 pending reads", exp_q.size(), 32'd0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule